// File: doc/BRIEF.md
# Shared-Port Correlation Buffer

This block is a two-port storage buffer that sits between consecutive computing stages of a block-based correlation datapath. It holds one full block of complex samples, each made of a signed real part and a signed imaginary part. The same storage is reused from phase to phase. In one phase it might hold filter output, and in a later phase it holds product results. Each new phase simply overwrites the entries of the previous one.

Port B is a single physical port shared by two neighbours. The upstream stage writes a complex sample when it raises its write enable. The downstream stage reads a sample when it raises its read enable. When both are raised in the same cycle, the write is carried out, the read is dropped, and a sticky collision flag is set. Port A is a read-only memory-mapped slave that lets a CPU or DMA engine inspect the contents at any time. Each entry occupies two bus words, one for the real part and one for the imaginary part. A read is answered after one cycle, together with a valid strobe. Write attempts on port A are discarded.

Port B is controlled by a state machine with four states: `PB_IDLE`, `PB_WROTE`, `PB_READ` and `PB_CLASH`. In every cycle the next state is chosen from the two enables. Both enables lead to `PB_CLASH`. The write enable alone leads to `PB_WROTE`. The read enable alone leads to `PB_READ`. Neither leads to `PB_IDLE`. The read strobe is high only in `PB_READ`.

Port A is controlled by a state machine with two states: `BUS_IDLE` and `BUS_RESP`. An accepted read moves it from `BUS_IDLE` to `BUS_RESP`. It always returns from `BUS_RESP` to `BUS_IDLE` after one cycle. The wait signal is high in `BUS_RESP` and low in `BUS_IDLE`.

Top module: `shared_port_buffer`

## Requirements
- R1: After reset, `bus_readdatavalid`, `bus_waitrequest`, `pb_rd_valid` and `pb_collide` are all 0.
- R2: When `pb_wr_en` is 1 at a clock edge, the pair {`pb_wr_re`, `pb_wr_im`} is stored at entry `pb_addr`.
- R3: When `pb_rd_en` is 1 and `pb_wr_en` is 0 at an edge, `pb_rd_valid` is 1 for the following cycle only. In that cycle, `pb_rd_re`/`pb_rd_im` show the contents of entry `pb_addr`.
- R4: When `pb_wr_en` and `pb_rd_en` are both 1 at an edge, the write is performed and `pb_rd_valid` stays 0 in the next cycle. `pb_collide` becomes 1 and stays 1 until reset.
- R5: A bus read is accepted when `bus_read` is 1 and `bus_waitrequest` is 0 at an edge. In the next cycle, `bus_readdatavalid` is 1 and `bus_readdata` holds the selected 24-bit part, sign-extended to 32 bits. Address bit 0 selects the part (0 = real, 1 = imaginary), and bits [AW:1] select the entry. While `bus_readdatavalid` is 0, `bus_readdata` is 0.
- R6: `bus_waitrequest` is 1 in the cycle after an accepted read. A read held high continuously is therefore answered every second cycle, and `bus_readdatavalid` is never 1 in two consecutive cycles.
- R7: `bus_write` never changes the contents and never produces `bus_readdatavalid`.
- R8: A bus read of an entry that port B writes at the same edge returns the entry's value from before that write.
- R9: Rewriting an entry in a later phase replaces its value for both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW+1 | Bus word address: bit 0 selects the part, the upper bits select the entry |
| bus_read | input | 1 | Bus read request |
| bus_write | input | 1 | Bus write request (discarded) |
| bus_waitrequest | output | 1 | Slave busy; the request is not accepted this cycle |
| bus_readdata | output | BW | Sign-extended part being returned |
| bus_readdatavalid | output | 1 | `bus_readdata` is valid |
| pb_addr | input | AW | Port B entry index |
| pb_wr_en | input | 1 | Producer write enable |
| pb_wr_re | input | DW | Real part to write |
| pb_wr_im | input | DW | Imaginary part to write |
| pb_rd_en | input | 1 | Consumer read enable |
| pb_rd_re | output | DW | Real part read |
| pb_rd_im | output | DW | Imaginary part read |
| pb_rd_valid | output | 1 | Port B read data valid |
| pb_collide | output | 1 | Sticky flag: a write and a read met on port B |

## Verification
Two activities can fall on the same cycle. The first is a bus readback on port A while the producer writes the same entry on port B. The bench provokes this by raising `bus_read` and `pb_wr_en` for the same edge on one entry. It expects the old value on the bus, and then the new value on a second readback. The second is a producer write meeting a consumer read on port B. The bench provokes this by raising both enables for one edge. It then checks that no read strobe appears, that the collision flag is set and stays set, and that a later read returns the written data.

// File: rtl/spb_pkg.sv
package spb_pkg;
    typedef enum logic [0:0] {
        BUS_IDLE,
        BUS_RESP
    } bus_state_e;

    typedef enum logic [1:0] {
        PB_IDLE,
        PB_WROTE,
        PB_READ,
        PB_CLASH
    } pb_state_e;
endpackage

// File: rtl/spb_mem.sv
module spb_mem #(
    parameter int AW = 11,
    parameter int DW = 24
) (
    input  logic              clk,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [AW-1:0]     b_addr,
    input  logic [2*DW-1:0]   b_wdata,
    output logic [2*DW-1:0]   b_rdata,
    input  logic              a_re,
    input  logic [AW-1:0]     a_addr,
    output logic [2*DW-1:0]   a_rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int WW    = 2 * DW;

    logic [WW-1:0] store [DEPTH];
    logic [WW-1:0] b_q;
    logic [WW-1:0] a_q;

    // Both reads sample the array before this edge's write lands (old data).
    always_ff @(posedge clk) begin
        if (b_we) begin
            store[b_addr] <= b_wdata;
        end
        if (b_re) begin
            b_q <= store[b_addr];
        end
        if (a_re) begin
            a_q <= store[a_addr];
        end
    end

    assign b_rdata = b_q;
    assign a_rdata = a_q;
endmodule

// File: rtl/spb_bport_ctrl.sv
module spb_bport_ctrl
    import spb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic rd_en,
    output logic mem_we,
    output logic mem_re,
    output logic rd_valid,
    output logic collide
);
    pb_state_e state_q, state_d;
    logic      collide_q;

    always_comb begin
        if (wr_en && rd_en) begin
            state_d = PB_CLASH;
        end else if (wr_en) begin
            state_d = PB_WROTE;
        end else if (rd_en) begin
            state_d = PB_READ;
        end else begin
            state_d = PB_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= PB_IDLE;
            collide_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            collide_q <= collide_q | (wr_en & rd_en);
        end
    end

    always_comb begin
        unique case (state_q)
            PB_IDLE:  rd_valid = 1'b0;
            PB_WROTE: rd_valid = 1'b0;
            PB_READ:  rd_valid = 1'b1;
            PB_CLASH: rd_valid = 1'b0;
            default:  rd_valid = 1'b0;
        endcase
    end

    // The write always wins; a read is passed on only when no write is present.
    assign mem_we  = wr_en;
    assign mem_re  = rd_en & ~wr_en;
    assign collide = collide_q;

    AST_BRD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rd_valid); // R3
    AST_BRD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_en && !wr_en)); // R3
    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |=> (collide && !rd_valid)); // R4
    AST_CLASH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> collide); // R4
endmodule

// File: rtl/spb_bus_slave.sv
module spb_bus_slave
    import spb_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 24,
    parameter int BW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW:0]     bus_addr,
    input  logic            bus_read,
    input  logic            bus_write,
    input  logic [2*DW-1:0] mem_word,
    output logic            mem_re,
    output logic [AW-1:0]   mem_addr,
    output logic            waitrequest,
    output logic            readdatavalid,
    output logic [BW-1:0]   readdata
);
    bus_state_e    state_q, state_d;
    logic          part_q;
    logic          accept;
    logic [DW-1:0] part_sel;
    logic [BW-1:0] part_ext;

    assign accept   = bus_read && (state_q == BUS_IDLE);
    assign mem_re   = accept;
    assign mem_addr = bus_addr[AW:1];

    always_comb begin
        unique case (state_q)
            BUS_IDLE: state_d = accept ? BUS_RESP : BUS_IDLE;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            part_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                part_q <= bus_addr[0];
            end
        end
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE: begin
                waitrequest   = 1'b0;
                readdatavalid = 1'b0;
            end
            BUS_RESP: begin
                waitrequest   = 1'b1;
                readdatavalid = 1'b1;
            end
            default: begin
                waitrequest   = 1'b0;
                readdatavalid = 1'b0;
            end
        endcase
    end

    // Word layout: real part in the upper half, imaginary part in the lower half.
    assign part_sel = part_q ? mem_word[DW-1:0] : mem_word[2*DW-1:DW];

    generate
        if (BW > DW) begin : g_extend
            assign part_ext = {{(BW-DW){part_sel[DW-1]}}, part_sel};
        end else begin : g_trunc
            assign part_ext = part_sel[BW-1:0];
        end
    endgenerate

    assign readdata = readdatavalid ? part_ext : '0;

    AST_BUS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_read && !waitrequest) |=> readdatavalid); // R5
    AST_BUS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        readdatavalid |=> !readdatavalid); // R6
    AST_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && !bus_read && !waitrequest) |=> !readdatavalid); // R7
endmodule

// File: rtl/shared_port_buffer.sv
module shared_port_buffer #(
    parameter int AW = 11,
    parameter int DW = 24,
    parameter int BW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   bus_addr,
    input  logic          bus_read,
    input  logic          bus_write,
    output logic          bus_waitrequest,
    output logic [BW-1:0] bus_readdata,
    output logic          bus_readdatavalid,
    input  logic [AW-1:0] pb_addr,
    input  logic          pb_wr_en,
    input  logic [DW-1:0] pb_wr_re,
    input  logic [DW-1:0] pb_wr_im,
    input  logic          pb_rd_en,
    output logic [DW-1:0] pb_rd_re,
    output logic [DW-1:0] pb_rd_im,
    output logic          pb_rd_valid,
    output logic          pb_collide
);
    localparam int WW = 2 * DW;

    logic          b_we, b_re, a_re;
    logic [AW-1:0] a_addr;
    logic [WW-1:0] b_rdata, a_rdata;

    spb_bport_ctrl u_bctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pb_wr_en),
        .rd_en    (pb_rd_en),
        .mem_we   (b_we),
        .mem_re   (b_re),
        .rd_valid (pb_rd_valid),
        .collide  (pb_collide)
    );

    spb_bus_slave #(.AW(AW), .DW(DW), .BW(BW)) u_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_read      (bus_read),
        .bus_write     (bus_write),
        .mem_word      (a_rdata),
        .mem_re        (a_re),
        .mem_addr      (a_addr),
        .waitrequest   (bus_waitrequest),
        .readdatavalid (bus_readdatavalid),
        .readdata      (bus_readdata)
    );

    spb_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .b_we    (b_we),
        .b_re    (b_re),
        .b_addr  (pb_addr),
        .b_wdata ({pb_wr_re, pb_wr_im}),
        .b_rdata (b_rdata),
        .a_re    (a_re),
        .a_addr  (a_addr),
        .a_rdata (a_rdata)
    );

    assign pb_rd_re = b_rdata[WW-1:DW];
    assign pb_rd_im = b_rdata[DW-1:0];

    AST_RESET_QUIET: assert property (@(posedge clk)
        $fell(rst_n) |=> (!bus_readdatavalid && !pb_rd_valid && !pb_collide)); // R1
endmodule

// File: tb/tb_shared_port_buffer.sv
module tb_shared_port_buffer;
    localparam int AW = 11;
    localparam int DW = 24;
    localparam int BW = 32;
    localparam int NV = 8;
    localparam int VW = AW + 2 * DW;

    // Each vector: {entry, real, imag}
    localparam logic [VW-1:0] VEC [NV] = '{
        {11'd0,    24'h000001, 24'h000002},
        {11'd1,    24'h7FFFFF, 24'h800000},
        {11'd2,    24'hFFFFFF, 24'h123456},
        {11'd17,   24'h800001, 24'h7FFFFE},
        {11'd255,  24'h0A0B0C, 24'hF0F0F0},
        {11'd1024, 24'h555555, 24'hAAAAAA},
        {11'd2046, 24'h000000, 24'hFFFFFE},
        {11'd2047, 24'hC00000, 24'h3FFFFF}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW:0]   bus_addr = '0;
    logic          bus_read = 1'b0;
    logic          bus_write = 1'b0;
    logic          bus_waitrequest;
    logic [BW-1:0] bus_readdata;
    logic          bus_readdatavalid;
    logic [AW-1:0] pb_addr = '0;
    logic          pb_wr_en = 1'b0;
    logic [DW-1:0] pb_wr_re = '0;
    logic [DW-1:0] pb_wr_im = '0;
    logic          pb_rd_en = 1'b0;
    logic [DW-1:0] pb_rd_re;
    logic [DW-1:0] pb_rd_im;
    logic          pb_rd_valid;
    logic          pb_collide;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shared_port_buffer #(.AW(AW), .DW(DW), .BW(BW)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_read(bus_read), .bus_write(bus_write),
        .bus_waitrequest(bus_waitrequest), .bus_readdata(bus_readdata),
        .bus_readdatavalid(bus_readdatavalid),
        .pb_addr(pb_addr), .pb_wr_en(pb_wr_en), .pb_wr_re(pb_wr_re),
        .pb_wr_im(pb_wr_im), .pb_rd_en(pb_rd_en), .pb_rd_re(pb_rd_re),
        .pb_rd_im(pb_rd_im), .pb_rd_valid(pb_rd_valid), .pb_collide(pb_collide)
    );

    function automatic logic [BW-1:0] sext(input logic [DW-1:0] v);
        return {{(BW-DW){v[DW-1]}}, v};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pb_write(input logic [AW-1:0] a, input logic [DW-1:0] re, input logic [DW-1:0] im);
        pb_addr = a; pb_wr_re = re; pb_wr_im = im; pb_wr_en = 1'b1;
        @(negedge clk);
        pb_wr_en = 1'b0;
    endtask

    task automatic pb_read_chk(input logic [AW-1:0] a, input logic [DW-1:0] re, input logic [DW-1:0] im, input string req);
        pb_addr = a; pb_rd_en = 1'b1;
        @(negedge clk);
        pb_rd_en = 1'b0;
        chk(pb_rd_valid == 1'b1, req, 64'(pb_rd_valid), 64'd1);
        chk({pb_rd_re, pb_rd_im} == {re, im}, req, 64'({pb_rd_re, pb_rd_im}), 64'({re, im}));
        @(negedge clk);
        chk(pb_rd_valid == 1'b0, {req, " strobe one cycle"}, 64'(pb_rd_valid), 64'd0);
    endtask

    task automatic bus_read_chk(input logic [AW:0] ba, input logic [BW-1:0] exp, input string req);
        chk(bus_waitrequest == 1'b0, "R6 idle wait low", 64'(bus_waitrequest), 64'd0);
        bus_addr = ba; bus_read = 1'b1;
        @(negedge clk);
        bus_read = 1'b0;
        chk(bus_readdatavalid == 1'b1, req, 64'(bus_readdatavalid), 64'd1);
        chk(bus_readdata == exp, req, 64'(bus_readdata), 64'(exp));
        chk(bus_waitrequest == 1'b1, "R6 wait after accept", 64'(bus_waitrequest), 64'd1);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(bus_readdatavalid == 1'b0, "R1 readdatavalid", 64'(bus_readdatavalid), 64'd0);
        chk(bus_waitrequest == 1'b0, "R1 waitrequest", 64'(bus_waitrequest), 64'd0);
        chk(pb_rd_valid == 1'b0, "R1 pb_rd_valid", 64'(pb_rd_valid), 64'd0);
        chk(pb_collide == 1'b0, "R1 pb_collide", 64'(pb_collide), 64'd0);

        // R2 fill from the vector table
        for (int i = 0; i < NV; i++) begin
            pb_write(VEC[i][VW-1:2*DW], VEC[i][2*DW-1:DW], VEC[i][DW-1:0]);
        end
        // R3 and R5 readback on both ports
        for (int i = 0; i < NV; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] re, im;
            a  = VEC[i][VW-1:2*DW];
            re = VEC[i][2*DW-1:DW];
            im = VEC[i][DW-1:0];
            pb_read_chk(a, re, im, "R2/R3 port B readback");
            bus_read_chk({a, 1'b0}, sext(re), "R5 bus real part");
            bus_read_chk({a, 1'b1}, sext(im), "R5 bus imag part");
        end

        // R7 bus write is discarded
        bus_addr = {11'd0, 1'b0}; bus_write = 1'b1;
        @(negedge clk);
        bus_write = 1'b0;
        chk(bus_readdatavalid == 1'b0, "R7 no valid on write", 64'(bus_readdatavalid), 64'd0);
        chk(bus_readdata == '0, "R7 readdata idle", 64'(bus_readdata), 64'd0);
        bus_read_chk({11'd0, 1'b0}, sext(24'h000001), "R7 contents unchanged");
        pb_read_chk(11'd0, 24'h000001, 24'h000002, "R7 contents unchanged port B");

        // R6 held read is answered every second cycle
        bus_addr = {11'd2, 1'b0}; bus_read = 1'b1;
        @(negedge clk);
        chk(bus_readdatavalid == 1'b1, "R6 first answer", 64'(bus_readdatavalid), 64'd1);
        chk(bus_readdata == sext(24'hFFFFFF), "R6 first data", 64'(bus_readdata), 64'(sext(24'hFFFFFF)));
        bus_addr = {11'd2, 1'b1};
        @(negedge clk);
        chk(bus_readdatavalid == 1'b0, "R6 gap cycle", 64'(bus_readdatavalid), 64'd0);
        chk(bus_waitrequest == 1'b0, "R6 wait released", 64'(bus_waitrequest), 64'd0);
        @(negedge clk);
        bus_read = 1'b0;
        chk(bus_readdatavalid == 1'b1, "R6 second answer", 64'(bus_readdatavalid), 64'd1);
        chk(bus_readdata == sext(24'h123456), "R6 second data", 64'(bus_readdata), 64'(sext(24'h123456)));
        @(negedge clk);

        // R8 same-cycle bus read and port B write on one entry
        bus_addr = {11'd1, 1'b0}; bus_read = 1'b1;
        pb_addr = 11'd1; pb_wr_re = 24'h13579B; pb_wr_im = 24'h2468AC; pb_wr_en = 1'b1;
        @(negedge clk);
        bus_read = 1'b0; pb_wr_en = 1'b0;
        chk(bus_readdata == sext(24'h7FFFFF), "R8 old data on overlap", 64'(bus_readdata), 64'(sext(24'h7FFFFF)));
        @(negedge clk);
        // R9 rewritten entry seen on both ports
        bus_read_chk({11'd1, 1'b0}, sext(24'h13579B), "R9 new phase bus");
        pb_read_chk(11'd1, 24'h13579B, 24'h2468AC, "R9 new phase port B");

        // R4 write and read together on port B
        pb_addr = 11'd17; pb_wr_re = 24'hABCDEF; pb_wr_im = 24'h010203;
        pb_wr_en = 1'b1; pb_rd_en = 1'b1;
        @(negedge clk);
        pb_wr_en = 1'b0; pb_rd_en = 1'b0;
        chk(pb_rd_valid == 1'b0, "R4 read dropped", 64'(pb_rd_valid), 64'd0);
        chk(pb_collide == 1'b1, "R4 flag set", 64'(pb_collide), 64'd1);
        repeat (3) @(negedge clk);
        chk(pb_collide == 1'b1, "R4 flag sticky", 64'(pb_collide), 64'd1);
        pb_read_chk(11'd17, 24'hABCDEF, 24'h010203, "R4 write won");

        // R1 reset clears the flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pb_collide == 1'b0, "R1 flag cleared by reset", 64'(pb_collide), 64'd0);

        finish_run();
    end
endmodule